// File: doc/BRIEF.md
# Hybrid Counter Flush Scheduler

This block keeps a bank of narrow per-flow event counters in fast local storage and decides, on a fixed slot cadence, which one to move into a wide accumulating counter array held in slow memory. Each time slot can add one to at most one counter. Every `FLUSH_PERIOD` slots the scheduler picks a single counter. It emits a flush command that carries the counter's index and its current value, and it clears that counter. The slow-memory side adds the value to its stored total. The local counters therefore only need to be wide enough to cover the growth between two visits.

Two selection policies are supported. The default policy works from two things: the largest counter touched since the last flush, and a bitmap of counters at or above the threshold `FLUSH_PERIOD`. The second policy is a plain rotating pointer, for which a counter may grow to `FLUSH_PERIOD*NUM_CTRS` before it is visited. The counter width must be sized for that bound. If an increment would exceed the counter width, the counter holds its maximum and a sticky error flag rises.

Top module: `hcf_flush_sched`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `flush_valid` and `overflow_err` are 0, and every counter, touched flag, bitmap bit, pointer and slot phase is zero.
- R2: An increment is accepted only in a cycle where `slot_tick` and `inc_valid` are both 1. An `inc_valid` without `slot_tick` has no effect on any later flush value.
- R3: Slot ticks are counted from reset. On every `FLUSH_PERIOD`-th tick (the 4th, 8th, ...) a flush decision is taken, and any resulting command is shown on `flush_valid`/`flush_idx`/`flush_value` for exactly one cycle, in the cycle after that tick. No command appears at any other time.
- R4: With `rr_mode`=0, j is the counter with the largest value among those incremented since the previous flush slot (ties go to the lowest index), and c is its value. If c >= `FLUSH_PERIOD`, counter j is flushed.
- R5: With `rr_mode`=0 and c < `FLUSH_PERIOD` (or nothing touched), if some counter holds a value >= `FLUSH_PERIOD`, the lowest such index is flushed.
- R6: With `rr_mode`=0, c < `FLUSH_PERIOD` and no counter at or above the threshold, counter j is flushed. If in addition no counter was touched, no command is issued.
- R7: The flushed value is the counter's value before the flush slot's own increment. The counter is cleared, and an increment to the same index in the same slot leaves it at 1. An increment in the flush slot counts as touched for the following period.
- R8: With `rr_mode`=1, every flush slot issues a command for the pointer index, even with value 0. The pointer starts at 0, steps by one per such slot, wraps after `NUM_CTRS-1`, and holds still during flush slots taken with `rr_mode`=0.
- R9: An increment to a counter already at all ones leaves it at all ones and sets `overflow_err`, which then stays 1 until reset.
- R10: For every index, the sum of flushed values plus the value left in the counter equals the number of accepted increments. After an idle round-robin drain, the sum of flushed values alone equals it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | Marks a time slot |
| inc_valid | input | 1 | Request to increment a counter in this slot |
| inc_idx | input | $clog2(NUM_CTRS) | Counter to increment |
| rr_mode | input | 1 | 1 selects the rotating-pointer policy |
| flush_valid | output | 1 | Flush command present |
| flush_idx | output | $clog2(NUM_CTRS) | Index of the flushed counter |
| flush_value | output | CTR_W | Value to add into the slow counter |
| overflow_err | output | 1 | Sticky counter overflow flag |

## Verification
Every result is registered once. A flush command and an overflow flag caused by the slot tick at a rising edge are visible from that edge until the next one. The bench drives each slot's inputs at the falling edge and updates its behavioural model for that slot at the same moment. It then samples the outputs at the following falling edge, so each comparison lands exactly one edge after the stimulus that caused it. The conservation property is checked at the ports. The bench accumulates every flushed value into its own slow array and, after a round-robin drain without increments, compares that array with its count of accepted increments.

// File: rtl/hcf_pkg.sv
package hcf_pkg;

    typedef enum logic [1:0] {
        PICK_NONE    = 2'd0,
        PICK_LARGEST = 2'd1,
        PICK_THRESH  = 2'd2
    } pick_e;

endpackage

// File: rtl/hcf_slot_timer.sv
module hcf_slot_timer #(
    parameter int PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic flush_slot_o
);
    localparam int PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

    logic [PH_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d      = phase_q;
        flush_slot_o = tick_i && (phase_q == LAST);
        if (tick_i) begin
            phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/hcf_lcf_select.sv
module hcf_lcf_select
    import hcf_pkg::*;
#(
    parameter int NUM_CTRS = 16,
    parameter int CTR_W    = 8,
    parameter int THRESH   = 4,
    localparam int IDX_W   = $clog2(NUM_CTRS)
) (
    input  logic [NUM_CTRS-1:0][CTR_W-1:0] ctr_i,
    input  logic [NUM_CTRS-1:0]            touched_i,
    input  logic [NUM_CTRS-1:0]            bitmap_i,
    output pick_e                          pick_o,
    output logic [IDX_W-1:0]               idx_o
);
    localparam logic [CTR_W-1:0] THR = CTR_W'(THRESH);

    logic             have_j;
    logic [IDX_W-1:0] j_idx;
    logic [CTR_W-1:0] j_val;
    logic             have_t;
    logic [IDX_W-1:0] t_idx;

    // largest touched counter; strict compare keeps the lowest index on ties
    always_comb begin
        have_j = 1'b0;
        j_idx  = '0;
        j_val  = '0;
        for (int i = 0; i < NUM_CTRS; i++) begin
            if (touched_i[i] && (!have_j || ctr_i[i] > j_val)) begin
                have_j = 1'b1;
                j_idx  = IDX_W'(i);
                j_val  = ctr_i[i];
            end
        end
    end

    // priority encoder: lowest set bitmap bit
    always_comb begin
        have_t = 1'b0;
        t_idx  = '0;
        for (int i = NUM_CTRS - 1; i >= 0; i--) begin
            if (bitmap_i[i]) begin
                have_t = 1'b1;
                t_idx  = IDX_W'(i);
            end
        end
    end

    always_comb begin
        pick_o = PICK_NONE;
        idx_o  = '0;
        if (have_j && j_val >= THR) begin
            pick_o = PICK_LARGEST;
            idx_o  = j_idx;
        end else if (have_t) begin
            pick_o = PICK_THRESH;
            idx_o  = t_idx;
        end else if (have_j) begin
            pick_o = PICK_LARGEST;
            idx_o  = j_idx;
        end
    end
endmodule

// File: rtl/hcf_flush_sched.sv
module hcf_flush_sched
    import hcf_pkg::*;
#(
    parameter int NUM_CTRS     = 16,
    parameter int FLUSH_PERIOD = 4,
    parameter int CTR_W        = 8,
    localparam int IDX_W       = $clog2(NUM_CTRS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_tick,
    input  logic             inc_valid,
    input  logic [IDX_W-1:0] inc_idx,
    input  logic             rr_mode,
    output logic             flush_valid,
    output logic [IDX_W-1:0] flush_idx,
    output logic [CTR_W-1:0] flush_value,
    output logic             overflow_err
);
    localparam logic [CTR_W-1:0] THR      = CTR_W'(FLUSH_PERIOD);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CTRS - 1);

    typedef struct packed {
        logic [NUM_CTRS-1:0][CTR_W-1:0] ctr;
        logic [NUM_CTRS-1:0]            touched;
        logic [NUM_CTRS-1:0]            bitmap;
        logic [IDX_W-1:0]               ptr;
        logic                           fl_valid;
        logic [IDX_W-1:0]               fl_idx;
        logic [CTR_W-1:0]               fl_value;
        logic                           err;
    } state_t;

    state_t st_d, st_q;

    logic             flush_slot;
    pick_e            lcf_pick;
    logic [IDX_W-1:0] lcf_idx;

    hcf_slot_timer #(.PERIOD(FLUSH_PERIOD)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (slot_tick),
        .flush_slot_o (flush_slot)
    );

    hcf_lcf_select #(
        .NUM_CTRS (NUM_CTRS),
        .CTR_W    (CTR_W),
        .THRESH   (FLUSH_PERIOD)
    ) u_select (
        .ctr_i     (st_q.ctr),
        .touched_i (st_q.touched),
        .bitmap_i  (st_q.bitmap),
        .pick_o    (lcf_pick),
        .idx_o     (lcf_idx)
    );

    logic             issue;
    logic [IDX_W-1:0] victim;

    always_comb begin
        st_d          = st_q;
        st_d.fl_valid = 1'b0;
        issue         = 1'b0;
        victim        = '0;

        if (flush_slot) begin
            if (rr_mode) begin
                issue    = 1'b1;
                victim   = st_q.ptr;
                st_d.ptr = (st_q.ptr == LAST_IDX) ? '0 : st_q.ptr + 1'b1;
            end else begin
                issue  = (lcf_pick != PICK_NONE);
                victim = lcf_idx;
            end
            st_d.touched = '0;
        end

        if (issue) begin
            st_d.fl_valid    = 1'b1;
            st_d.fl_idx      = victim;
            st_d.fl_value    = st_q.ctr[victim];
            st_d.ctr[victim] = '0;
        end

        // increment lands after the clear so a same-slot hit is kept
        if (slot_tick && inc_valid && (int'(inc_idx) < NUM_CTRS)) begin
            st_d.touched[inc_idx] = 1'b1;
            if (&st_d.ctr[inc_idx]) st_d.err = 1'b1;
            else                    st_d.ctr[inc_idx] = st_d.ctr[inc_idx] + 1'b1;
        end

        for (int i = 0; i < NUM_CTRS; i++) begin
            st_d.bitmap[i] = (st_d.ctr[i] >= THR);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flush_valid  = st_q.fl_valid;
    assign flush_idx    = st_q.fl_idx;
    assign flush_value  = st_q.fl_value;
    assign overflow_err = st_q.err;
endmodule

// File: rtl/hcf_flush_sched_chk.sv
module hcf_flush_sched_chk #(
    parameter int FLUSH_PERIOD = 4,
    parameter int CTR_W        = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slot_tick,
    input logic             rr_mode,
    input logic             flush_valid,
    input logic [CTR_W-1:0] flush_value,
    input logic             overflow_err
);
    int ticks_q;

    always_ff @(posedge clk) begin
        if (!rst_n)           ticks_q <= 0;
        else if (flush_valid) ticks_q <= slot_tick ? 1 : 0;
        else if (slot_tick)   ticks_q <= ticks_q + 1;
    end

    // R3
    flush_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> $past(slot_tick));

    // R3
    flush_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> !flush_valid);

    // R3
    flush_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (ticks_q != 0 && (ticks_q % FLUSH_PERIOD) == 0));

    // R6
    lcf_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && !$past(rr_mode)) |-> (flush_value != '0));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);
endmodule

bind hcf_flush_sched hcf_flush_sched_chk #(
    .FLUSH_PERIOD (FLUSH_PERIOD),
    .CTR_W        (CTR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_tick    (slot_tick),
    .rr_mode      (rr_mode),
    .flush_valid  (flush_valid),
    .flush_value  (flush_value),
    .overflow_err (overflow_err)
);

// File: tb/hcf_flush_sched_tb.sv
module hcf_flush_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int B  = 4;
    localparam int W  = 8;
    localparam int IW = $clog2(N);
    localparam int MAXV = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_tick = 1'b0, inc_valid = 1'b0, rr_mode = 1'b0;
    logic [IW-1:0] inc_idx = '0;
    logic flush_valid, overflow_err;
    logic [IW-1:0] flush_idx;
    logic [W-1:0] flush_value;

    logic n_tick = 1'b0, n_inc = 1'b0;
    logic [IW-1:0] n_idx = '0;
    logic n_fv, n_err;
    logic [IW-1:0] n_fi;
    logic [2:0] n_fval;

    always #(CLK_PERIOD/2) clk = ~clk;

    hcf_flush_sched #(.NUM_CTRS(N), .FLUSH_PERIOD(B), .CTR_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .inc_valid(inc_valid),
        .inc_idx(inc_idx), .rr_mode(rr_mode), .flush_valid(flush_valid),
        .flush_idx(flush_idx), .flush_value(flush_value), .overflow_err(overflow_err));

    hcf_flush_sched #(.NUM_CTRS(N), .FLUSH_PERIOD(B), .CTR_W(3)) u_narrow (
        .clk(clk), .rst_n(rst_n), .slot_tick(n_tick), .inc_valid(n_inc),
        .inc_idx(n_idx), .rr_mode(1'b1), .flush_valid(n_fv),
        .flush_idx(n_fi), .flush_value(n_fval), .overflow_err(n_err));

    int tests = 0, fails = 0;
    int sm[N], slow[N], refc[N];
    bit touched[N];
    int phase = 0, ptr = 0;

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one slot: drive at falling edge, model it, check at next falling edge
    task automatic slot(bit tk, bit iv, int idx, bit rr);
        bit ev; int ei, evl; string tag;
        slot_tick = tk; inc_valid = iv; inc_idx = IW'(idx); rr_mode = rr;
        ev = 0; ei = 0; evl = 0; tag = "R3";
        if (tk) begin
            if (phase == B - 1) begin
                phase = 0;
                if (rr) begin
                    ev = 1; ei = ptr; ptr = (ptr + 1) % N; tag = "R8";
                end else begin
                    bit hj = 0, ht = 0; int jv = 0, ji = 0, ti = 0;
                    for (int i = 0; i < N; i++)
                        if (touched[i] && (!hj || sm[i] > jv)) begin hj = 1; jv = sm[i]; ji = i; end
                    for (int i = 0; i < N; i++)
                        if (!ht && sm[i] >= B) begin ht = 1; ti = i; end
                    if (hj && jv >= B) begin ev = 1; ei = ji; tag = "R4"; end
                    else if (ht)       begin ev = 1; ei = ti; tag = "R5"; end
                    else if (hj)       begin ev = 1; ei = ji; tag = "R6"; end
                    else tag = "R6";
                end
                if (ev) begin evl = sm[ei]; sm[ei] = 0; end
                for (int i = 0; i < N; i++) touched[i] = 0;
            end else phase++;
            if (iv) begin
                touched[idx] = 1;
                if (sm[idx] < MAXV) sm[idx]++;
                refc[idx]++;
            end
        end
        @(posedge clk); @(negedge clk);
        check(flush_valid === ev, {tag, " flush_valid"}, int'(flush_valid), int'(ev));
        if (ev && flush_valid === 1'b1) begin
            check(int'(flush_idx) == ei, {tag, " flush_idx"}, int'(flush_idx), ei);
            check(int'(flush_value) == evl, "R7 flush_value", int'(flush_value), evl);
        end
        if (flush_valid === 1'b1) slow[flush_idx] += int'(flush_value);
        check(overflow_err === 1'b0, "R9 no overflow", int'(overflow_err), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++; tests++;
        $display("FAIL R3: watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin sm[i] = 0; slow[i] = 0; refc[i] = 0; touched[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(flush_valid === 1'b0, "R1 flush_valid in reset", int'(flush_valid), 0);
        check(overflow_err === 1'b0, "R1 err in reset", int'(overflow_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(flush_valid === 1'b0, "R1 flush_valid after reset", int'(flush_valid), 0);

        // build a counter above threshold under round robin (R8 slots 0,1)
        for (int s = 0; s < 7; s++) slot(1, 1, 9, 1);
        slot(1, 0, 0, 1);
        // R2: increments without a tick are ignored
        for (int s = 0; s < 5; s++) slot(0, 1, 9, 0);
        // R5: touched max is 2, counter 9 holds 7
        slot(1, 1, 5, 0); slot(1, 1, 5, 0); slot(1, 0, 0, 0); slot(1, 0, 0, 0);
        // R4: touched counter 5 reaches 4
        slot(1, 1, 5, 0); slot(1, 1, 5, 0); slot(1, 0, 0, 0); slot(1, 0, 0, 0);
        // R6: only counter 2 touched with value 1
        slot(1, 1, 2, 0); slot(1, 0, 0, 0); slot(1, 0, 0, 0); slot(1, 0, 0, 0);
        // R6: nothing touched, nothing above threshold -> no command
        for (int s = 0; s < 4; s++) slot(1, 0, 0, 0);
        // R7: same-slot hit on the flushed counter
        slot(1, 1, 3, 0); slot(1, 1, 3, 0); slot(1, 1, 3, 0); slot(1, 1, 3, 0);
        slot(1, 1, 3, 0); slot(1, 0, 0, 0); slot(1, 0, 0, 0); slot(1, 1, 6, 0);

        // mixed traffic, threshold policy
        for (int s = 0; s < 400; s++)
            slot($urandom_range(9, 0) != 0, $urandom_range(4, 0) != 0,
                 ($urandom_range(3, 0) == 0) ? $urandom_range(N-1, 0) : $urandom_range(5, 0), 0);
        // mixed traffic, round robin
        for (int s = 0; s < 150; s++)
            slot($urandom_range(9, 0) != 0, $urandom_range(3, 0) != 0, $urandom_range(N-1, 0), 1);
        // idle round-robin drain empties every counter
        for (int s = 0; s < N * B + B; s++) slot(1, 0, 0, 1);
        for (int i = 0; i < N; i++)
            check(slow[i] == refc[i], $sformatf("R10 conservation idx %0d (R2 ignored incs)", i), slow[i], refc[i]);

        // R9: narrow instance, 3-bit counters, hammer index 15
        for (int s = 0; s < 7; s++) begin
            n_tick = 1; n_inc = 1; n_idx = 4'd15; @(posedge clk); @(negedge clk);
        end
        check(n_err === 1'b0, "R9 no error at all ones", int'(n_err), 0);
        n_tick = 1; n_inc = 1; n_idx = 4'd15; @(posedge clk); @(negedge clk);
        check(n_err === 1'b1, "R9 error on overflow", int'(n_err), 1);
        n_tick = 0; n_inc = 0;
        repeat (6) @(negedge clk);
        check(n_err === 1'b1, "R9 error sticky", int'(n_err), 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule